// File: doc/BRIEF.md
# Dark-Offset Calibration Controller

This controller finds the 8-bit code for an output-offset DAC that cancels a thermopile's dark signal at the end of a two-stage gain chain. After a start pulse, it collects a fixed, power-of-two number of signed ADC samples, each in millivolts relative to the output common mode, taken while the light source is off. It averages them with an accumulator and an arithmetic shift. It then turns the mean into a DAC code and issues a one-cycle write strobe with that code.

The DAC's transfer has its midpoint at 128 and a negative slope of 33.8 mV per step. A positive measured offset therefore needs a code above 128 to cancel it. The controller counts a parameterised number of clock cycles so that the DAC can settle. It then averages a second set of samples and reports that residual offset as a signed value. No second write is made. While the run is in progress, the busy flag is high. Once the residual is available, the done flag is high.

Top module: `dark_offset_cal`

## Requirements
- R1: Out of reset, dac_code_o is 128 (0x80, zero shift), and dac_wr_o, busy_o, done_o, sat_o and resid_mv_o are all zero.
- R2: A start_i pulse seen while idle or done begins a dark phase. In that phase, exactly 2**LOG2_N cycles with smp_valid_i high are accumulated, and cycles with smp_valid_i low are skipped. The mean is the sum shifted right arithmetically by LOG2_N, which rounds it toward minus infinity.
- R3: The code equals 128 + k. k is the mean's magnitude times 10, plus 169, divided by 338 (integer division), and carries the sign of the mean. This is rounding to the nearest 33.8 mV step, with ties going away from zero.
- R4: When 128 + k is above 255, the code is 255. When it is below 0, the code is 0. In either case sat_o is 1 from the write onward. A calculation that does not clamp clears sat_o.
- R5: dac_wr_o is high for exactly one cycle per run. That cycle is the second cycle after the edge that takes the last dark sample. dac_code_o changes only at the edge that raises dac_wr_o.
- R6: The settle window lasts SETTLE_CYC cycles and starts with the write cycle. Samples presented during the window are ignored.
- R7: After the settle window, 2**LOG2_N further valid samples are averaged in the same way as in R2. The result appears on resid_mv_o at the edge that takes the last of them.
- R8: busy_o is high from the edge after start until the residual is stored. done_o is high from that edge until the next accepted start. A start_i pulse while busy_o is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a calibration run (ignored while busy) |
| smp_valid_i | input | 1 | Sample qualifier |
| smp_mv_i | input | SW | Signed ADC sample in mV about common mode |
| dac_code_o | output | 8 | Offset DAC code |
| dac_wr_o | output | 1 | One-cycle register-write request for dac_code_o |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Residual ready, DAC settled |
| sat_o | output | 1 | Last computed code was clamped |
| resid_mv_o | output | SW | Signed mean residual after the write |

## Verification
A wrong sample count or a wrong shift shows up as early as the write cycle. The code is off by one or more steps, or the strobe arrives one cycle early or late. Both are visible on the cycle they happen, because every output is compared against a reference model on every clock. A settle counter that stops at the wrong value moves the sample window of the residual phase. This shows up as done_o rising on the wrong cycle and as a different resid_mv_o. Clamp and rounding faults are exposed by runs whose means sit far outside ±4.3 V, near the ±16.9 mV rounding boundary, and at small negative values where flooring matters.

// File: rtl/dark_offset_cal.sv
module dark_offset_cal #(
  parameter int SW         = 16,
  parameter int LOG2_N     = 4,
  parameter int STEP_X10   = 338,
  parameter int SETTLE_CYC = 120000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 smp_valid_i,
  input  logic signed [SW-1:0] smp_mv_i,
  output logic [7:0]           dac_code_o,
  output logic                 dac_wr_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 sat_o,
  output logic signed [SW-1:0] resid_mv_o
);
  localparam int N  = 1 << LOG2_N;
  localparam int AW = SW + LOG2_N;
  localparam int PW = SW + 6;
  localparam int CW = $clog2(SETTLE_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_DARK, S_CALC, S_SETTLE, S_RESID, S_DONE} st_t;
  st_t st;

  logic signed [AW-1:0] acc;
  logic [LOG2_N-1:0]    ncnt;
  logic [CW-1:0]        scnt;

  wire                  take   = smp_valid_i && (st == S_DARK || st == S_RESID);
  wire                  last   = take && ncnt == LOG2_N'(N - 1);
  wire signed [AW-1:0]  sum_w  = acc + AW'(smp_mv_i);
  wire signed [SW-1:0]  mean_w = SW'(acc >>> LOG2_N);
  wire                  neg    = mean_w[SW-1];
  wire signed [PW-1:0]  mext   = PW'(mean_w);
  wire [PW-1:0]         magu   = neg ? PW'(-mext) : PW'(mext);
  wire [PW-1:0]         quo    = (magu * PW'(10) + PW'(STEP_X10 / 2)) / PW'(STEP_X10);
  wire                  clip   = neg ? (quo > PW'(128)) : (quo > PW'(127));
  wire [7:0]            code_w = clip ? (neg ? 8'd0 : 8'd255)
                                      : (neg ? 8'(9'd128 - 9'(quo)) : 8'(9'd128 + 9'(quo)));

  assign busy_o = st == S_DARK || st == S_CALC || st == S_SETTLE || st == S_RESID;
  assign done_o = st == S_DONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      acc        <= '0;
      ncnt       <= '0;
      scnt       <= '0;
      dac_code_o <= 8'h80;
      dac_wr_o   <= 1'b0;
      sat_o      <= 1'b0;
      resid_mv_o <= '0;
    end else begin
      dac_wr_o <= 1'b0;
      if (take) begin
        acc  <= sum_w;
        ncnt <= ncnt + LOG2_N'(1);
      end
      case (st)
        S_IDLE, S_DONE:
          if (start_i) begin
            st   <= S_DARK;
            acc  <= '0;
            ncnt <= '0;
          end
        S_DARK:
          if (last) st <= S_CALC;
        S_CALC: begin
          dac_code_o <= code_w;
          sat_o      <= clip;
          dac_wr_o   <= 1'b1;
          scnt       <= '0;
          st         <= S_SETTLE;
        end
        S_SETTLE:
          if (scnt == CW'(SETTLE_CYC - 1)) begin
            st   <= S_RESID;
            acc  <= '0;
            ncnt <= '0;
          end else begin
            scnt <= scnt + CW'(1);
          end
        S_RESID:
          if (last) begin
            resid_mv_o <= SW'(sum_w >>> LOG2_N);
            st         <= S_DONE;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    dac_wr_o |=> !dac_wr_o); // R5
  AST_CODE_ONLY_ON_WR: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_wr_o |-> $stable(dac_code_o)); // R5
  AST_SAT_AT_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_wr_o && sat_o) |-> (dac_code_o == 8'd0 || dac_code_o == 8'd255)); // R4
  AST_WR_INSIDE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    dac_wr_o |=> (busy_o && !done_o)); // R6
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o)); // R8
  AST_RESID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(done_o)) |-> $stable(resid_mv_o)); // R7
endmodule

// File: tb/sim_dark_offset_cal.sv
module sim_dark_offset_cal;
  localparam int SW = 16, LOG2_N = 4, SETTLE = 50, NS = 1 << LOG2_N;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, smp_valid_i = 1'b0;
  logic signed [SW-1:0] smp_mv_i = '0;
  logic [7:0] dac_code_o;
  logic dac_wr_o, busy_o, done_o, sat_o;
  logic signed [SW-1:0] resid_mv_o;

  always #2 clk = ~clk;

  dark_offset_cal #(.SW(SW), .LOG2_N(LOG2_N), .STEP_X10(338), .SETTLE_CYC(SETTLE)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .smp_valid_i(smp_valid_i),
    .smp_mv_i(smp_mv_i), .dac_code_o(dac_code_o), .dac_wr_o(dac_wr_o),
    .busy_o(busy_o), .done_o(done_o), .sat_o(sat_o), .resid_mv_o(resid_mv_o));

  int vectors = 0, misses = 0;
  int phase = 0, cnt = 0;
  int q[$];
  int e_code = 128, e_wr = 0, e_sat = 0, e_res = 0;

  function automatic int floor_mean();
    int s = 0;
    foreach (q[i]) s += q[i];
    return s >>> LOG2_N;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      phase = 0; cnt = 0; q.delete();
      e_code = 128; e_wr = 0; e_sat = 0; e_res = 0;
    end else begin
      e_wr = 0;
      case (phase)
        0, 5: if (start_i) begin phase = 1; q.delete(); end
        1: begin
          if (smp_valid_i) q.push_back(int'(smp_mv_i));
          if (q.size() == NS) phase = 2;
        end
        2: begin
          int m, a, k, n;
          m = floor_mean();
          a = (m < 0) ? -m : m;
          k = (a * 10 + 169) / 338;
          if (m < 0) k = -k;
          n = 128 + k;
          e_sat = (n < 0 || n > 255) ? 1 : 0;
          e_code = (n < 0) ? 0 : (n > 255) ? 255 : n;
          e_wr = 1; cnt = 0; phase = 3;
        end
        3: begin
          cnt++;
          if (cnt == SETTLE) begin phase = 4; q.delete(); end
        end
        4: begin
          if (smp_valid_i) q.push_back(int'(smp_mv_i));
          if (q.size() == NS) begin e_res = floor_mean(); phase = 5; end
        end
        default: phase = 0;
      endcase
    end
  end

  task automatic cmp(string tag, int act, int exp);
    if (act != exp) begin
      misses++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    vectors++;
    cmp(rst_n ? "R2/R3 code" : "R1 code", int'(dac_code_o), e_code);
    cmp(rst_n ? "R5/R6 wr" : "R1 wr", int'(dac_wr_o), e_wr);
    cmp(rst_n ? "R4 sat" : "R1 sat", int'(sat_o), e_sat);
    cmp(rst_n ? "R8 busy" : "R1 busy", int'(busy_o), (phase >= 1 && phase <= 4) ? 1 : 0);
    cmp(rst_n ? "R8 done" : "R1 done", int'(done_o), (phase == 5) ? 1 : 0);
    cmp(rst_n ? "R7 resid" : "R1 resid", int'(resid_mv_o), e_res);
  end

  task automatic run(int base, int spread, int gap_pct, bit poke_start);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    while (phase != 5) begin
      smp_valid_i = ($urandom % 100) >= gap_pct;
      smp_mv_i = SW'(base + (spread == 0 ? 0 : int'($urandom % (2 * spread + 1)) - spread));
      start_i = poke_start && ($urandom % 8 == 0);
      @(negedge clk);
    end
    smp_valid_i = 1'b0; start_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  bit timeout = 0;
  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        run(0, 0, 30, 0);         // R3 zero offset -> 128
        run(17, 0, 0, 0);         // R3 rounds up to 129
        run(16, 0, 50, 0);        // R3 rounds down to 128
        run(-17, 0, 20, 1);       // R3 negative, R8 start ignored
        run(-100, 40, 25, 0);     // R2 floor of negative mean
        run(20000, 3000, 10, 0);  // R4 upper clamp
        run(50, 10, 10, 0);       // R4 sat cleared
        run(-20000, 3000, 40, 1); // R4 lower clamp
        run(-1, 1, 0, 0);         // R2/R7 small negative flooring
        for (int i = 0; i < 6; i++) run(int'($urandom % 8001) - 4000, 600, 30, 1);
      end
      begin
        repeat (150000) @(posedge clk);
        timeout = 1;
      end
    join_any
    disable fork;
    if (timeout) begin
      misses++;
      $display("FAIL watchdog expired");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule